// File: doc/BRIEF.md
# Single-Cycle Load/Store Integer Core

This block is a small 32-bit processor that finishes every instruction in one clock. It supports seven instructions. Two are register-to-register arithmetic: add and subtract. There is an OR with an immediate, a word load, a word store, a branch on equality and an absolute jump. The core holds the program counter, a 32-entry register file, a three-function ALU and the immediate extender. It also contains a decoder that builds every control line as an OR of per-instruction match terms.

Instruction and data storage are two small word arrays inside the block. A side port writes words into either array, normally while the core is held in reset. A registered peek port reads one data word back. Each instruction that completes is reported on registered trace outputs one clock after it executes. The report gives the address of the instruction, the register write it made (if any) and the memory store it made (if any). A test harness or an enclosing system can follow execution from these outputs alone.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter and every trace output become zero. The first instruction executed after release is the one at byte address 0.
- R2: An instruction that is neither a taken branch nor a jump moves the program counter to its own address plus 4. `pc_o` shows the new value after the same edge at which the instruction executes.
- R3: Opcode 000000 is the register form. Within it, function 100000 writes rs+rt and function 100010 writes rs−rt (modulo 2^32) to the register named by bits 15:11.
- R4: Opcode 001101 writes rs OR {16'h0, imm} to the register named by bits 20:16. The immediate is always zero-extended.
- R5: Opcode 100011 loads and opcode 101011 stores the data word at byte address rs + sign-extended imm. The load writes to the register named by bits 20:16. The store writes that register's value to memory and writes no register.
- R6: Opcode 000100 compares rs with rt. When they are equal, the next PC is PC+4 plus the sign-extended immediate shifted left by 2. When they differ, the next PC is PC+4.
- R7: Opcode 000010 sets the next PC to {PC+4[31:28], bits 25:0 of the instruction, 2'b00}.
- R8: Register 0 always reads as zero. An instruction that names it as destination leaves no register write on the trace.
- R9: Any other opcode, and any register-form function other than the two listed, writes no register and no memory, and advances the PC by 4.
- R10: The trace outputs show the instruction retired at the last edge. When no register write happened, the register write address and data are zero. When no store happened, the store address and data are zero.
- R11: With `ld_we` high, `ld_data` is written at word `ld_addr` of the instruction array when `ld_imem` is 1, and of the data array when it is 0. `peek_data_o` shows data word `peek_addr` one edge after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Load-port write strobe |
| ld_imem | input | 1 | Load target: 1 instruction array, 0 data array |
| ld_addr | input | MEM_AW | Load word address |
| ld_data | input | 32 | Load word |
| peek_addr | input | MEM_AW | Data-array word to read back |
| pc_o | output | 32 | Current program counter |
| tr_pc_o | output | 32 | Address of the instruction retired at the last edge |
| tr_rf_we_o | output | 1 | Retired instruction wrote a register |
| tr_rf_wa_o | output | 5 | Register written |
| tr_rf_wd_o | output | 32 | Value written |
| tr_dm_we_o | output | 1 | Retired instruction stored to memory |
| tr_dm_addr_o | output | 32 | Store byte address |
| tr_dm_wd_o | output | 32 | Store data |
| peek_data_o | output | 32 | Registered data-array read |

## Verification
Several properties are checked by the assertions on every cycle:
- the PC reaches zero under reset and steps by 4 on straight-line flow;
- the decoded instruction kinds stay mutually exclusive;
- stores happen only for the store opcode;
- nothing is ever reported as written to register 0;
- undecodable words leave no trace of a write.

Only the bench's program can show that the arithmetic, extension and addressing produce the right values. The same holds for branch and jump targets landing where intended, for skipped instructions never retiring, and for stored data being readable through both a later load and the peek port.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN   = 32;
  localparam int REG_AW = 5;
  localparam int NREGS  = 1 << REG_AW;

  localparam logic [5:0] OPC_RTYPE = 6'b000000;
  localparam logic [5:0] OPC_ORI   = 6'b001101;
  localparam logic [5:0] OPC_LW    = 6'b100011;
  localparam logic [5:0] OPC_SW    = 6'b101011;
  localparam logic [5:0] OPC_BEQ   = 6'b000100;
  localparam logic [5:0] OPC_J     = 6'b000010;
  localparam logic [5:0] FN_ADD    = 6'b100000;
  localparam logic [5:0] FN_SUB    = 6'b100010;

  typedef enum logic [1:0] {
    ALU_ADD = 2'b00,
    ALU_SUB = 2'b01,
    ALU_OR  = 2'b10
  } alu_op_e;

  typedef struct packed {
    logic    dst_is_rd;
    logic    b_is_imm;
    logic    wb_from_mem;
    logic    rf_we;
    logic    dm_we;
    logic    br_sel;
    logic    jmp_sel;
    logic    imm_signed;
    alu_op_e alu_op;
    logic    illegal;
  } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl,
  output logic [6:0] kind_vec
);
  logic is_r, is_add, is_sub, is_ori, is_lw, is_sw, is_beq, is_j;

  always_comb begin
    is_r   = (opcode == OPC_RTYPE);
    is_add = is_r && (funct == FN_ADD);
    is_sub = is_r && (funct == FN_SUB);
    is_ori = (opcode == OPC_ORI);
    is_lw  = (opcode == OPC_LW);
    is_sw  = (opcode == OPC_SW);
    is_beq = (opcode == OPC_BEQ);
    is_j   = (opcode == OPC_J);

    ctrl.dst_is_rd   = is_add | is_sub;
    ctrl.b_is_imm    = is_ori | is_lw | is_sw;
    ctrl.wb_from_mem = is_lw;
    ctrl.rf_we       = is_add | is_sub | is_ori | is_lw;
    ctrl.dm_we       = is_sw;
    ctrl.br_sel      = is_beq;
    ctrl.jmp_sel     = is_j;
    ctrl.imm_signed  = is_lw | is_sw | is_beq;
    ctrl.alu_op      = alu_op_e'({is_ori, is_sub | is_beq});
    ctrl.illegal     = !(is_add | is_sub | is_ori | is_lw | is_sw | is_beq | is_j);
    kind_vec         = {is_add, is_sub, is_ori, is_lw, is_sw, is_beq, is_j};
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    unique case (op)
      ALU_SUB: y = a - b;
      ALU_OR:  y = a | b;
      default: y = a + b;
    endcase
    zero = (y == '0);
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2
);
  localparam int N = 1 << AW;
  logic [W-1:0] regs_q [N];

  always_ff @(posedge clk) begin
    if (we && (wa != '0)) regs_q[wa] <= wd;
  end

  always_comb begin
    rd1 = (ra1 == '0) ? '0 : regs_q[ra1];
    rd2 = (ra2 == '0) ? '0 : regs_q[ra2];
  end
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_we,
  input  logic              ld_imem,
  input  logic [MEM_AW-1:0] ld_addr,
  input  logic [XLEN-1:0]   ld_data,
  input  logic [MEM_AW-1:0] peek_addr,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   tr_pc_o,
  output logic              tr_rf_we_o,
  output logic [REG_AW-1:0] tr_rf_wa_o,
  output logic [XLEN-1:0]   tr_rf_wd_o,
  output logic              tr_dm_we_o,
  output logic [XLEN-1:0]   tr_dm_addr_o,
  output logic [XLEN-1:0]   tr_dm_wd_o,
  output logic [XLEN-1:0]   peek_data_o
);
  localparam int MEM_WORDS = 1 << MEM_AW;

  logic [XLEN-1:0] imem [MEM_WORDS];
  logic [XLEN-1:0] dmem [MEM_WORDS];
  logic [XLEN-1:0] pc_q;

  logic [XLEN-1:0]   instr;
  logic [5:0]        opcode, funct;
  logic [REG_AW-1:0] f_rs, f_rt, f_rd;
  logic [15:0]       imm16;
  logic [25:0]       tgt26;
  ctrl_t             ctrl;
  logic [6:0]        kind_vec;

  logic [XLEN-1:0]   imm_ext, rs_val, rt_val, alu_b, alu_y, mem_rd, wb_data;
  logic              alu_zero, br_taken, wr_eff;
  logic [REG_AW-1:0] wb_addr;
  logic [XLEN-1:0]   pc_plus4, pc_br, pc_next;

  always_comb begin
    instr  = imem[pc_q[MEM_AW+1:2]];
    opcode = instr[31:26];
    f_rs   = instr[25:21];
    f_rt   = instr[20:16];
    f_rd   = instr[15:11];
    funct  = instr[5:0];
    imm16  = instr[15:0];
    tgt26  = instr[25:0];
  end

  sc_decode u_dec (
    .opcode   (opcode),
    .funct    (funct),
    .ctrl     (ctrl),
    .kind_vec (kind_vec)
  );

  sc_regfile #(.W(XLEN), .AW(REG_AW)) u_rf (
    .clk (clk),
    .we  (wr_eff),
    .wa  (wb_addr),
    .wd  (wb_data),
    .ra1 (f_rs),
    .ra2 (f_rt),
    .rd1 (rs_val),
    .rd2 (rt_val)
  );

  always_comb begin
    imm_ext = ctrl.imm_signed ? {{(XLEN-16){imm16[15]}}, imm16} : {{(XLEN-16){1'b0}}, imm16};
    alu_b   = ctrl.b_is_imm ? imm_ext : rt_val;
  end

  sc_alu #(.W(XLEN)) u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .op   (ctrl.alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  always_comb begin
    mem_rd   = dmem[alu_y[MEM_AW+1:2]];
    wb_data  = ctrl.wb_from_mem ? mem_rd : alu_y;
    wb_addr  = ctrl.dst_is_rd ? f_rd : f_rt;
    wr_eff   = !rst && ctrl.rf_we && (wb_addr != '0);
    pc_plus4 = pc_q + XLEN'(4);
    pc_br    = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
    br_taken = ctrl.br_sel && alu_zero;
    if (ctrl.jmp_sel)  pc_next = {pc_plus4[31:28], tgt26, 2'b00};
    else if (br_taken) pc_next = pc_br;
    else               pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (ld_we && ld_imem) imem[ld_addr] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (ld_we && !ld_imem)      dmem[ld_addr] <= ld_data;
    else if (!rst && ctrl.dm_we) dmem[alu_y[MEM_AW+1:2]] <= rt_val;
    peek_data_o <= dmem[peek_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q         <= '0;
      tr_pc_o      <= '0;
      tr_rf_we_o   <= 1'b0;
      tr_rf_wa_o   <= '0;
      tr_rf_wd_o   <= '0;
      tr_dm_we_o   <= 1'b0;
      tr_dm_addr_o <= '0;
      tr_dm_wd_o   <= '0;
    end else begin
      pc_q         <= pc_next;
      tr_pc_o      <= pc_q;
      tr_rf_we_o   <= wr_eff;
      tr_rf_wa_o   <= wr_eff ? wb_addr : '0;
      tr_rf_wd_o   <= wr_eff ? wb_data : '0;
      tr_dm_we_o   <= ctrl.dm_we;
      tr_dm_addr_o <= ctrl.dm_we ? alu_y : '0;
      tr_dm_wd_o   <= ctrl.dm_we ? rt_val : '0;
    end
  end

  assign pc_o = pc_q;

  // R1: reset clears the program counter
  p_pc_reset_r1: assert property (@(posedge clk) rst |=> (pc_o == '0));

  // R2: straight-line flow steps by one word
  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.jmp_sel && !br_taken) |=> (pc_o == $past(pc_o) + XLEN'(4)));

  // R3: at most one instruction kind decoded
  p_kind_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(kind_vec));

  // R5: memory is written only by the store opcode
  p_store_only_sw_r5: assert property (@(posedge clk) disable iff (rst)
    ctrl.dm_we |-> (opcode == OPC_SW));

  // R8: register 0 never appears as a retired write
  p_no_r0_write_r8: assert property (@(posedge clk) disable iff (rst)
    tr_rf_we_o |-> (tr_rf_wa_o != '0));

  // R9: an undecodable word leaves no write on the trace
  p_illegal_nop_r9: assert property (@(posedge clk) disable iff (rst)
    ctrl.illegal |=> (!tr_rf_we_o && !tr_dm_we_o));
endmodule

// File: tb/sc_core_tb.sv
module sc_core_tb_top;
  localparam int AW = 6;
  localparam int NSTEP = 18;
  localparam int NPROG = 21;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_we = 1'b0, ld_imem = 1'b0;
  logic [AW-1:0] ld_addr = '0, peek_addr = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] pc_o, tr_pc_o, tr_rf_wd_o, tr_dm_addr_o, tr_dm_wd_o, peek_data_o;
  logic tr_rf_we_o, tr_dm_we_o;
  logic [4:0] tr_rf_wa_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [31:0] prog [NPROG];

  always #5 clk = ~clk;

  sc_core #(.MEM_AW(AW)) dut_i (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_imem(ld_imem), .ld_addr(ld_addr),
    .ld_data(ld_data), .peek_addr(peek_addr), .pc_o(pc_o), .tr_pc_o(tr_pc_o),
    .tr_rf_we_o(tr_rf_we_o), .tr_rf_wa_o(tr_rf_wa_o), .tr_rf_wd_o(tr_rf_wd_o),
    .tr_dm_we_o(tr_dm_we_o), .tr_dm_addr_o(tr_dm_addr_o), .tr_dm_wd_o(tr_dm_wd_o),
    .peek_data_o(peek_data_o)
  );

  // {pc, next pc, rf_we, wa, wd, dm_we, dm addr, dm data}
  localparam logic [166:0] EXP [NSTEP] = '{
    {32'd0,  32'd4,  1'b1, 5'd1, 32'h5,        1'b0, 32'h0, 32'h0},          // R4
    {32'd4,  32'd8,  1'b1, 5'd2, 32'h0000FFFF, 1'b0, 32'h0, 32'h0},          // R4 zero ext
    {32'd8,  32'd12, 1'b1, 5'd3, 32'h00010004, 1'b0, 32'h0, 32'h0},          // R3 add
    {32'd12, 32'd16, 1'b1, 5'd4, 32'hFFFF0006, 1'b0, 32'h0, 32'h0},          // R3 sub
    {32'd16, 32'd20, 1'b0, 5'd0, 32'h0,        1'b1, 32'd8, 32'h00010004},   // R5 sw
    {32'd20, 32'd24, 1'b1, 5'd5, 32'h00010004, 1'b0, 32'h0, 32'h0},          // R5 lw
    {32'd24, 32'd28, 1'b1, 5'd7, 32'd12,       1'b0, 32'h0, 32'h0},
    {32'd28, 32'd32, 1'b0, 5'd0, 32'h0,        1'b1, 32'd8, 32'hFFFF0006},   // R5 negative offset
    {32'd32, 32'd36, 1'b1, 5'd8, 32'hFFFF0006, 1'b0, 32'h0, 32'h0},
    {32'd36, 32'd40, 1'b0, 5'd0, 32'h0,        1'b0, 32'h0, 32'h0},          // R8 write to r0
    {32'd40, 32'd44, 1'b1, 5'd9, 32'h5,        1'b0, 32'h0, 32'h0},          // R8 read r0
    {32'd44, 32'd48, 1'b0, 5'd0, 32'h0,        1'b0, 32'h0, 32'h0},          // R6 not taken
    {32'd48, 32'd60, 1'b0, 5'd0, 32'h0,        1'b0, 32'h0, 32'h0},          // R6 taken
    {32'd60, 32'd64, 1'b0, 5'd0, 32'h0,        1'b0, 32'h0, 32'h0},          // R9 opcode
    {32'd64, 32'd68, 1'b0, 5'd0, 32'h0,        1'b0, 32'h0, 32'h0},          // R9 funct
    {32'd68, 32'd80, 1'b0, 5'd0, 32'h0,        1'b0, 32'h0, 32'h0},          // R7 jump
    {32'd80, 32'd80, 1'b0, 5'd0, 32'h0,        1'b0, 32'h0, 32'h0},          // R6 backward
    {32'd80, 32'd80, 1'b0, 5'd0, 32'h0,        1'b0, 32'h0, 32'h0}
  };

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'h0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic load_word(input logic to_imem, input int a, input logic [31:0] d);
    @(negedge clk);
    ld_we = 1'b1; ld_imem = to_imem; ld_addr = AW'(a); ld_data = d;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <=5000", cyc);
      finish_run();
    end
  end

  initial begin
    prog[0]  = enc_i(6'h0D, 0, 1, 16'h0005);
    prog[1]  = enc_i(6'h0D, 0, 2, 16'hFFFF);
    prog[2]  = enc_r(1, 2, 3, 6'h20);
    prog[3]  = enc_r(1, 2, 4, 6'h22);
    prog[4]  = enc_i(6'h2B, 0, 3, 16'h0008);
    prog[5]  = enc_i(6'h23, 0, 5, 16'h0008);
    prog[6]  = enc_i(6'h0D, 0, 7, 16'h000C);
    prog[7]  = enc_i(6'h2B, 7, 4, 16'hFFFC);
    prog[8]  = enc_i(6'h23, 0, 8, 16'h0008);
    prog[9]  = enc_r(1, 1, 0, 6'h20);
    prog[10] = enc_r(0, 1, 9, 6'h20);
    prog[11] = enc_i(6'h04, 1, 2, 16'h0005);
    prog[12] = enc_i(6'h04, 5, 3, 16'h0002);
    prog[13] = enc_i(6'h0D, 0, 10, 16'hDEAD);
    prog[14] = enc_i(6'h0D, 0, 10, 16'hBEEF);
    prog[15] = {6'h3F, 26'h0ABCDEF};
    prog[16] = enc_r(1, 1, 11, 6'h25);
    prog[17] = {6'h02, 26'd20};
    prog[18] = enc_i(6'h0D, 0, 12, 16'h0001);
    prog[19] = enc_i(6'h0D, 0, 12, 16'h0002);
    prog[20] = enc_i(6'h04, 0, 0, 16'hFFFF);

    for (int i = 0; i < NPROG; i++) load_word(1'b1, i, prog[i]);
    load_word(1'b0, 0, 32'h12345678);
    load_word(1'b0, 2, 32'h0);

    @(negedge clk);
    chk("R1 pc under reset", pc_o, 32'h0);
    chk("R1 trace pc under reset", tr_pc_o, 32'h0);
    chk("R1 trace we under reset", {30'h0, tr_rf_we_o, tr_dm_we_o}, 32'h0);

    rst = 1'b0;
    for (int s = 0; s < NSTEP; s++) begin
      @(posedge clk);
      @(negedge clk);
      chk($sformatf("R10 step %0d retired pc", s), tr_pc_o, EXP[s][166:135]);
      chk($sformatf("R2/R6/R7 step %0d next pc", s), pc_o, EXP[s][134:103]);
      chk($sformatf("R10 step %0d rf we", s), {31'h0, tr_rf_we_o}, {31'h0, EXP[s][102]});
      chk($sformatf("R10 step %0d rf addr", s), {27'h0, tr_rf_wa_o}, {27'h0, EXP[s][101:97]});
      chk($sformatf("R3/R4/R5 step %0d rf data", s), tr_rf_wd_o, EXP[s][96:65]);
      chk($sformatf("R5 step %0d dm we", s), {31'h0, tr_dm_we_o}, {31'h0, EXP[s][64]});
      chk($sformatf("R5 step %0d dm addr", s), tr_dm_addr_o, EXP[s][63:32]);
      chk($sformatf("R5 step %0d dm data", s), tr_dm_wd_o, EXP[s][31:0]);
    end

    peek_addr = AW'(2);
    @(posedge clk); @(negedge clk);
    chk("R11 peek stored word", peek_data_o, 32'hFFFF0006);
    peek_addr = AW'(0);
    @(posedge clk); @(negedge clk);
    chk("R11 peek loaded word", peek_data_o, 32'h12345678);

    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1 pc after mid-run reset", pc_o, 32'h0);
    chk("R1 trace cleared", tr_rf_wd_o | tr_pc_o, 32'h0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R1 restart at address 0", tr_pc_o, 32'h0);
    chk("R2 restart next pc", pc_o, 32'h4);
    chk("R4 restart write value", tr_rf_wd_o, 32'h5);

    finish_run();
  end
endmodule